// File: doc/BRIEF.md
# MDIO Management Master with Snapshot Status Word

This block is a clause 22 MDIO management master that a host controls through a small byte-addressed register window. The host usually reaches the window through a serial bridge that moves one byte per access. The host fills a 32-bit control word with the PHY address, the register address, the operation and, for writes, the data. It then sets the top bit to start a frame. The block generates MDC, shifts the 64-bit management frame onto MDIO and, for reads, releases the line at turnaround and collects the 16 bits the PHY returns.

The same word reports the result. Its low half holds the value of the most recent completed read and its top bit is the busy flag. A host poll is a four-byte burst. Reading the lowest byte latches the busy flag and the upper data byte into a snapshot, and the three higher bytes are served from that snapshot. Because of this, a poll that straddles the end of a frame returns busy together with the old data, never cleared busy with a half-updated pair. A host that sees busy simply retries on its next poll.

Top module: `mdio_mgmt_window`

## Requirements
- R1: After reset the status word reads as all zero, MDC is low and MDIO is not driven.
- R2: While a frame runs, MDC is high for HALF_DIV clocks and low for HALF_DIV clocks. When the rate bit (word bit 27) is set at start, both phases are SLOW_MUL times longer. MDC stays low when idle.
- R3: A read frame (word bit 26 = 0) is 32 ones, then 01, then 10, then PHY address and register address (5 bits each, MSB first). MDIO is released for both turnaround bits. The 16 data bits are sampled on MDC rising edges.
- R4: A write frame (word bit 26 = 1) is 32 ones, then 01, then 01, then PHY and register address, then turnaround 10 and the 16 data bits from word bits 15:0, all driven by the block.
- R5: The word sits at byte addresses BASE_ADDR to BASE_ADDR+3, in little-endian order. Bits 15:0 are the write data, bits 20:16 the register address, bits 25:21 the PHY address, bit 26 the operation, bit 27 the rate select and bit 31 the start command. A write of the top byte with bit 7 set starts the frame using that byte's fields.
- R6: Busy (read bit 31) rises on the cycle after a start and clears at the MDC falling edge that ends bit 63. A completed read then shows the returned value in bits 15:0.
- R7: While busy, bits 15:0 keep the previous read result.
- R8: Reading BASE_ADDR returns live bits 7:0 and latches busy and bits 15:8. Reads of BASE_ADDR+1 and BASE_ADDR+3 return the latched values even if the frame has completed since.
- R9: A start command written while busy is ignored: no extra frame is sent and the running frame is unchanged.
- R10: The configuration fields are write-only. Byte BASE_ADDR+2 and bits 30:24 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
A PHY model on the bench decodes every frame and returns contents from a register array. Writes followed by reads of the same PHY register show that addresses, data and turnaround line up in both directions. Reads of untouched registers separate the PHY and register address fields. A slow-rate read shows that the rate bit alters only the MDC period. A poll started during a read and finished after it shows that the snapshot pairs the stale busy flag with the old data. A second start sent during a read shows that the command is dropped, because no write frame reaches the model and the target register keeps its old value.

// File: rtl/mdio_mgmt_window.sv
module mdio_mgmt_window #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4C,
  parameter int HALF_DIV = 10,
  parameter int SLOW_MUL = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DIV_W = $clog2(HALF_DIV * SLOW_MUL);
  localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(HALF_DIV * SLOW_MUL - 1);
  localparam logic [5:0] TA_BIT = 6'd46;
  localparam logic [5:0] DATA_BIT = 6'd48;
  localparam logic [5:0] LAST_BIT = 6'd63;

  logic [15:0]      cfg_wdat;
  logic [4:0]       cfg_reg;
  logic [4:0]       cfg_phy;
  logic             busy;
  logic             op_wr_q;
  logic             slow_q;
  logic             mdc_q;
  logic [DIV_W-1:0] div_cnt;
  logic [5:0]       bit_idx;
  logic [63:0]      tx_sr;
  logic [15:0]      rx_sr;
  logic [15:0]      rd_data;
  logic             snap_busy;
  logic [7:0]       snap_hi;

  wire sel0 = bus_addr == BASE_ADDR;
  wire sel1 = bus_addr == BASE_ADDR + ADDR_W'(1);
  wire sel2 = bus_addr == BASE_ADDR + ADDR_W'(2);
  wire sel3 = bus_addr == BASE_ADDR + ADDR_W'(3);

  wire       go      = bus_wr && sel3 && bus_wdata[7] && !busy;
  wire [4:0] go_phy  = {bus_wdata[1:0], cfg_phy[2:0]};
  wire       go_wr   = bus_wdata[2];
  wire       go_slow = bus_wdata[3];
  wire [63:0] frame  = {32'hFFFF_FFFF, 2'b01, go_wr ? 2'b01 : 2'b10, go_phy, cfg_reg,
                        go_wr ? {2'b10, cfg_wdat} : 18'h3FFFF};

  wire tick = busy && (div_cnt == (slow_q ? LIM_SLOW : LIM_FAST));
  wire rise = tick && !mdc_q;
  wire fall = tick && mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_wdat <= '0;
      cfg_reg  <= '0;
      cfg_phy  <= '0;
    end else if (bus_wr) begin
      if (sel0) cfg_wdat[7:0]  <= bus_wdata;
      if (sel1) cfg_wdat[15:8] <= bus_wdata;
      if (sel2) {cfg_phy[2:0], cfg_reg} <= bus_wdata;
      if (sel3) cfg_phy[4:3] <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_wr_q <= 1'b0;
      slow_q  <= 1'b0;
      mdc_q   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rd_data <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      op_wr_q <= go_wr;
      slow_q  <= go_slow;
      mdc_q   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sr   <= frame;
    end else if (busy) begin
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
      if (tick) mdc_q <= !mdc_q;
      if (rise && !op_wr_q && bit_idx >= DATA_BIT)
        rx_sr <= {rx_sr[14:0], mdio_i};
      if (fall) begin
        if (bit_idx == LAST_BIT) begin
          busy <= 1'b0;
          if (!op_wr_q) rd_data <= rx_sr;
        end else begin
          bit_idx <= bit_idx + 6'd1;
          tx_sr   <= {tx_sr[62:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_busy <= 1'b0;
      snap_hi   <= '0;
    end else if (bus_rd && sel0) begin
      snap_busy <= busy;
      snap_hi   <= rd_data[15:8];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel0) bus_rdata = rd_data[7:0];
    if (sel1) bus_rdata = snap_hi;
    if (sel3) bus_rdata = {snap_busy, 7'b0};
  end

  assign mdc     = mdc_q;
  assign mdio_o  = tx_sr[63];
  assign mdio_oe = busy && (op_wr_q || bit_idx < TA_BIT);
endmodule

// File: rtl/mdio_mgmt_window_chk.sv
module mdio_mgmt_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        op_wr_q,
  input logic [15:0] rd_data
);
  // R2
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  // R2
  mdc_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(mdc) |-> busy);
  // R6
  start_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !mdc);
  // R7
  data_update_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $fell(busy));
  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_wr_q));
endmodule

bind mdio_mgmt_window mdio_mgmt_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .op_wr_q(op_wr_q), .rd_data(rd_data)
);

// File: tb/test_mdio_mgmt_window.sv
module test_mdio_mgmt_window;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int SLOW = 10;
  localparam logic [15:0] BASE = 16'h004C;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_oe = 0, phy_bit = 0;

  int total = 0, bad = 0;
  logic [25:0] exp_wr[$];
  logic [15:0] exp_rd[$];
  logic [15:0] mem [1024];
  logic exp_slow = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  mdio_mgmt_window #(.ADDR_W(16), .BASE_ADDR(BASE), .HALF_DIV(HALF), .SLOW_MUL(SLOW))
    i_mdio_mgmt_window (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic logic [15:0] init_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, ~p[2:0], r[2:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model and write scoreboard monitor
  int cnt = 0;
  logic [63:0] sh = '0;
  logic [15:0] rsp = '0;
  logic oe_at_ta = 0;
  longint t_last = 0;
  always @(posedge mdc) begin
    sh = {sh[62:0], mdio_i};
    if (cnt == 46) oe_at_ta = mdio_oe;
    if (cnt == 10) begin
      // R2 MDC period
      check("R2 mdc period", 32'($time - t_last),
            32'(CLK_PERIOD * 2 * HALF * (exp_slow ? SLOW : 1)));
    end
    t_last = $time;
    if (cnt == 63) begin
      check("R3/R4 preamble", sh[63:32], 32'hFFFF_FFFF);
      check("R3/R4 start bits", 32'(sh[31:30]), 32'h1);
      check("R3/R4 turnaround", 32'(sh[17:16]), 32'h2);
      if (sh[29:28] == 2'b01) begin
        // R4 write frame against scoreboard
        if (exp_wr.size() == 0) check("R4/R9 unexpected write frame", 32'(sh[27:0]), 32'h0);
        else check("R4 write frame fields", 32'({sh[27:18], sh[15:0]}), 32'(exp_wr.pop_front()));
        mem[sh[27:18]] = sh[15:0];
      end else begin
        check("R3 read op code", 32'(sh[29:28]), 32'h2);
        check("R3 released at turnaround", 32'(oe_at_ta), 32'h0);
      end
      cnt = 0;
    end else cnt++;
  end

  always @(negedge mdc) begin
    if (cnt == 47 && sh[12:11] == 2'b10) begin
      rsp = mem[sh[10:1]];
      phy_oe = 1; phy_bit = 0;
    end else if (cnt >= 48 && phy_oe) phy_bit = rsp[63 - cnt];
    else if (cnt == 0) phy_oe = 0;
  end

  always @(posedge clk) if (phy_oe && mdio_oe) check("R3 bus contention", 1, 0);

  task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic burst(output logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    bread(BASE, b0); bread(BASE + 1, b1); bread(BASE + 2, b2); bread(BASE + 3, b3);
    w = {b3, b2, b1, b0};
  endtask

  task automatic start_op(input logic wr, input logic slow, input logic [4:0] p,
                          input logic [4:0] r, input logic [15:0] d);
    bwrite(BASE, d[7:0]); bwrite(BASE + 1, d[15:8]); bwrite(BASE + 2, {p[2:0], r});
    bwrite(BASE + 3, {1'b1, 3'b0, slow, wr, p[4:3]});
  endtask

  task automatic poll(input string req);
    logic [31:0] w;
    w = 32'h8000_0000;
    for (int i = 0; i < 5000 && w[31]; i++) burst(w);
    check({req, " busy cleared"}, 32'(w[31]), 32'h0);
    check({req, " upper bits zero"}, 32'(w[30:16]), 32'h0);
    if (exp_rd.size() != 0) check({req, " read data"}, 32'(w[15:0]), 32'(exp_rd.pop_front()));
  endtask

  task automatic do_write(input logic slow, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    exp_slow = slow; exp_wr.push_back({p, r, d});
    start_op(1, slow, p, r, d); poll("R4 R6 write");
  endtask

  task automatic do_read(input logic slow, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] e);
    exp_slow = slow; exp_rd.push_back(e);
    start_op(0, slow, p, r, 16'h0); poll("R3 R6 read");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(5'(i >> 5), 5'(i));
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    repeat (4) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    burst(w);
    check("R1 reset word", w, 32'h0);
    check("R1 reset mdc", 32'(mdc), 0);
    check("R1 reset oe", 32'(mdio_oe), 0);

    // R4 R5 write, then R3 readback
    do_write(0, 5'd3, 5'd5, 16'hBEEF);
    do_read(0, 5'd3, 5'd5, 16'hBEEF);
    do_read(0, 5'd1, 5'd2, init_val(5'd1, 5'd2));
    do_write(0, 5'd22, 5'd17, 16'h0A5C);
    do_read(0, 5'd22, 5'd17, 16'h0A5C);
    // R2 slow rate
    do_read(1, 5'd31, 5'd31, init_val(5'd31, 5'd31));

    // R6 R7 R8 R10 snapshot across completion; previous data init_val(31,31)
    exp_slow = 0;
    start_op(0, 0, 5'd4, 5'd9, 16'h0);
    repeat (5) @(negedge clk);
    bread(BASE, b);
    check("R7 R8 live low byte while busy", 32'(b), 32'(init_val(5'd31, 5'd31) & 16'hFF));
    repeat (64 * 2 * HALF + 20) @(negedge clk);
    bread(BASE + 1, b);
    check("R8 snapshot high byte", 32'(b), 32'(init_val(5'd31, 5'd31) >> 8));
    bread(BASE + 2, b);
    check("R10 config byte reads zero", 32'(b), 0);
    bread(BASE + 3, b);
    check("R8 snapshot busy kept", 32'(b), 32'h80);
    exp_rd.push_back(init_val(5'd4, 5'd9));
    poll("R6 R8 next poll");

    // R9 start while busy is ignored
    exp_slow = 0;
    start_op(0, 0, 5'd2, 5'd7, 16'h0);
    start_op(1, 0, 5'd9, 5'd1, 16'h1234);
    exp_rd.push_back(init_val(5'd2, 5'd7));
    poll("R9 running read intact");
    repeat (64 * 2 * HALF + 20) @(negedge clk);
    do_read(0, 5'd9, 5'd1, init_val(5'd9, 5'd1));
    check("R9 no leftover write", 32'(exp_wr.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule